// File: doc/BRIEF.md
# Binary64 to Binary32 Narrowing Converter with Round-to-Odd

This block takes one IEEE 754 double-precision operand per strobe and returns the single-precision value closest to it under round-to-odd. Nothing is ever incremented. The fraction is cut down toward zero first. If any dropped bit was nonzero, the lowest result bit is then forced to one. This keeps the information that a discarded tail existed. A later narrowing step can then round correctly without double-rounding error.

Each conversion also produces four exception indications. These are ORed into a sticky flag register that only a reset or an explicit clear strobe empties. The result, the flag update and an output strobe all appear one clock after the input strobe.

Top module: `f64_to_f32_odd`

## Requirements
- R1: `out_valid` is high exactly in the cycle after an `in_valid` cycle. `out_data` takes its new value in that same cycle. `out_data` holds its value while no operand is presented.
- R2: A finite input whose biased exponent E lies in 897..1150 gives exponent field E-896 and fraction bits 51..29 of the input fraction, with the sign kept. If any of input fraction bits 28..0 is set, result bit 0 is forced to one and inexact is raised. Otherwise the result is unchanged and no flag is raised.
- R3: A finite input with biased exponent 1151 or more gives the largest finite single, sign kept (magnitude 0x7F7FFFFF), and raises overflow and inexact. A finite input never yields exponent field 0xFF.
- R4: A finite input with biased exponent 896 or less (input subnormals count as exponent 1 with a hidden zero) gives a single subnormal. Its magnitude field is the 53-bit significand shifted right by 30-(E-896), with bit 0 forced to one if any shifted-out bit was nonzero. An inexact tiny result raises underflow and inexact. An exact one raises nothing.
- R5: Signed zeros and infinities pass through with their sign and raise no flag.
- R6: A NaN input yields sign kept, exponent field 0xFF, fraction bit 22 set and fraction bits 21..0 equal to input fraction bits 50..29. Invalid is raised exactly when input fraction bit 51 is zero (signaling NaN).
- R7: `flags_o` bit 3 is invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact. Each conversion ORs its flags into `flags_o` one cycle after `in_valid`. A conversion never clears a flag that is already set.
- R8: `flag_clr` empties the flag register at the next edge. When it coincides with `in_valid`, the register then holds only that conversion's flags.
- R9: While reset is low, `out_valid`, `out_data` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Binary64 operand |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Binary32 result |
| flags_o | output | 4 | Sticky flags {invalid, overflow, underflow, inexact} |

## Verification
The datapath holds no state between operands. A wrong classification, exponent rebias or shift count therefore shows up in `out_data` of the very conversion that exposes it, one cycle after the strobe. The sticky flag register is the only state that spans operands. A bit dropped or set wrongly there stays visible on `flags_o` at every later comparison until the next clear. The bench therefore tracks its own accumulated flag image and compares it after every operation and every idle cycle.

// File: rtl/rto_pkg.sv
package rto_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO,
      CLS_FINITE,
      CLS_INF,
      CLS_QNAN,
      CLS_SNAN
   } op_class_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } exc_flags_t;

   localparam int NUM_FLAGS = $bits(exc_flags_t);

endpackage

// File: rtl/rto_classify.sv
module rto_classify
   import rto_pkg::*;
#(
   parameter int EW = 11,
   parameter int FW = 52
) (
   input  logic [EW+FW:0] op_i,
   output logic           sign_o,
   output logic [EW-1:0]  exp_o,
   output logic [FW:0]    mant_o,
   output logic [FW-2:0]  payload_o,
   output op_class_e      cls_o
);

   localparam logic [EW-1:0] EXP_ALL1 = '1;

   logic [EW-1:0] raw_exp;
   logic [FW-1:0] raw_frac;

   assign sign_o    = op_i[EW+FW];
   assign raw_exp   = op_i[EW+FW-1:FW];
   assign raw_frac  = op_i[FW-1:0];
   assign payload_o = raw_frac[FW-2:0];

   always_comb begin
      // subnormal operands act as exponent 1 with no hidden bit
      mant_o = {(raw_exp != '0), raw_frac};
      exp_o  = (raw_exp == '0) ? EW'(1) : raw_exp;
      if (raw_exp == EXP_ALL1) begin
         if (raw_frac == '0)        cls_o = CLS_INF;
         else if (raw_frac[FW-1])   cls_o = CLS_QNAN;
         else                       cls_o = CLS_SNAN;
      end else if (raw_exp == '0 && raw_frac == '0) begin
         cls_o = CLS_ZERO;
      end else begin
         cls_o = CLS_FINITE;
      end
   end

endmodule

// File: rtl/rto_narrow.sv
module rto_narrow #(
   parameter int IEW = 11,
   parameter int IFW = 52,
   parameter int OEW = 8,
   parameter int OFW = 23
) (
   input  logic [IEW-1:0] exp_i,
   input  logic [IFW:0]   mant_i,
   output logic [OEW-1:0] exp_o,
   output logic [OFW-1:0] frac_o,
   output logic           sticky_o,
   output logic           tiny_o,
   output logic           ovf_o
);

   localparam int IBIAS = (1 << (IEW - 1)) - 1;
   localparam int OBIAS = (1 << (OEW - 1)) - 1;
   localparam int DROP  = IFW - OFW;
   localparam int MW    = IFW + 1;
   localparam int SW    = IEW + 2;
   localparam int SHW   = $clog2(MW + 1);

   localparam logic signed [SW-1:0] BIAS_DIFF_S = SW'(IBIAS - OBIAS);
   localparam logic signed [SW-1:0] MAX_FIN_S   = SW'((1 << OEW) - 2);
   localparam logic signed [SW-1:0] ONE_S       = SW'(1);
   localparam logic signed [SW-1:0] DROP_P1_S   = SW'(DROP + 1);
   localparam logic signed [SW-1:0] MW_S        = SW'(MW);

   logic signed [SW-1:0] reb_exp;
   logic signed [SW-1:0] sh_full;
   logic [SHW-1:0]       sh;
   logic [MW-1:0]        lost_mask;

   assign reb_exp = $signed({2'b00, exp_i}) - BIAS_DIFF_S;
   assign ovf_o   = reb_exp > MAX_FIN_S;
   assign tiny_o  = reb_exp < ONE_S;
   assign sh_full = DROP_P1_S - reb_exp;

   generate
      if (DROP + 1 + IBIAS - OBIAS >= MW) begin : g_clamped_shift
         // the denormalizing shift can run past the whole significand
         assign sh = tiny_o ? ((sh_full >= MW_S) ? SHW'(MW) : sh_full[SHW-1:0])
                            : SHW'(DROP);
      end else begin : g_plain_shift
         assign sh = tiny_o ? sh_full[SHW-1:0] : SHW'(DROP);
      end
   endgenerate

   assign lost_mask = ~({MW{1'b1}} << sh);
   assign frac_o    = OFW'(mant_i >> sh);
   assign sticky_o  = |(mant_i & lost_mask);
   assign exp_o     = tiny_o ? '0 : reb_exp[OEW-1:0];

endmodule

// File: rtl/rto_pack.sv
module rto_pack
   import rto_pkg::*;
#(
   parameter int OEW = 8,
   parameter int OFW = 23
) (
   input  logic           sign_i,
   input  op_class_e      cls_i,
   input  logic [OEW-1:0] exp_i,
   input  logic [OFW-1:0] frac_i,
   input  logic           sticky_i,
   input  logic           tiny_i,
   input  logic           ovf_i,
   input  logic [OFW-2:0] payload_i,
   output logic [OEW+OFW:0] res_o,
   output exc_flags_t     flags_o
);

   localparam logic [OEW-1:0] EXP_ALL1    = '1;
   localparam logic [OEW-1:0] EXP_MAX_FIN = {{(OEW-1){1'b1}}, 1'b0};

   always_comb begin
      res_o   = '0;
      flags_o = '0;
      unique case (cls_i)
         CLS_ZERO: res_o = {sign_i, {(OEW+OFW){1'b0}}};
         CLS_INF:  res_o = {sign_i, EXP_ALL1, {OFW{1'b0}}};
         CLS_QNAN, CLS_SNAN: begin
            res_o           = {sign_i, EXP_ALL1, 1'b1, payload_i};
            flags_o.invalid = (cls_i == CLS_SNAN);
         end
         default: begin
            if (ovf_i) begin
               // truncation saturates at the largest finite magnitude
               res_o            = {sign_i, EXP_MAX_FIN, {OFW{1'b1}}};
               flags_o.overflow = 1'b1;
               flags_o.inexact  = 1'b1;
            end else begin
               res_o             = {sign_i, exp_i, frac_i[OFW-1:1], frac_i[0] | sticky_i};
               flags_o.inexact   = sticky_i;
               flags_o.underflow = tiny_i & sticky_i;
            end
         end
      endcase
   end

endmodule

// File: rtl/f64_to_f32_odd.sv
module f64_to_f32_odd
   import rto_pkg::*;
#(
   parameter int IN_EXP_W  = 11,
   parameter int IN_FRAC_W = 52,
   parameter int OUT_EXP_W = 8,
   parameter int OUT_FRAC_W = 23,
   localparam int IN_W  = 1 + IN_EXP_W + IN_FRAC_W,
   localparam int OUT_W = 1 + OUT_EXP_W + OUT_FRAC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [IN_W-1:0]      in_data,
   input  logic                 flag_clr,
   output logic                 out_valid,
   output logic [OUT_W-1:0]     out_data,
   output logic [NUM_FLAGS-1:0] flags_o
);

   generate
      if (IN_EXP_W <= OUT_EXP_W) begin : g_err_exp
         $error("input exponent must be wider than output exponent");
      end
      if (IN_FRAC_W <= OUT_FRAC_W) begin : g_err_frac
         $error("input fraction must be wider than output fraction");
      end
      if (OUT_FRAC_W < 2) begin : g_err_small
         $error("output fraction needs a quiet bit and a payload");
      end
   endgenerate

   logic                    op_sign;
   logic [IN_EXP_W-1:0]     op_exp;
   logic [IN_FRAC_W:0]      op_mant;
   logic [IN_FRAC_W-2:0]    op_payload;
   op_class_e               op_cls;

   logic [OUT_EXP_W-1:0]    nar_exp;
   logic [OUT_FRAC_W-1:0]   nar_frac;
   logic                    nar_sticky;
   logic                    nar_tiny;
   logic                    nar_ovf;

   logic [OUT_W-1:0]        conv_res;
   exc_flags_t              conv_flags;
   logic [NUM_FLAGS-1:0]    conv_flag_bits;
   logic [NUM_FLAGS-1:0]    flags_q;

   rto_classify #(.EW(IN_EXP_W), .FW(IN_FRAC_W)) u_classify (
      .op_i      (in_data),
      .sign_o    (op_sign),
      .exp_o     (op_exp),
      .mant_o    (op_mant),
      .payload_o (op_payload),
      .cls_o     (op_cls)
   );

   rto_narrow #(
      .IEW(IN_EXP_W), .IFW(IN_FRAC_W), .OEW(OUT_EXP_W), .OFW(OUT_FRAC_W)
   ) u_narrow (
      .exp_i    (op_exp),
      .mant_i   (op_mant),
      .exp_o    (nar_exp),
      .frac_o   (nar_frac),
      .sticky_o (nar_sticky),
      .tiny_o   (nar_tiny),
      .ovf_o    (nar_ovf)
   );

   rto_pack #(.OEW(OUT_EXP_W), .OFW(OUT_FRAC_W)) u_pack (
      .sign_i    (op_sign),
      .cls_i     (op_cls),
      .exp_i     (nar_exp),
      .frac_i    (nar_frac),
      .sticky_i  (nar_sticky),
      .tiny_i    (nar_tiny),
      .ovf_i     (nar_ovf),
      .payload_i (op_payload[IN_FRAC_W-2 -: OUT_FRAC_W-1]),
      .res_o     (conv_res),
      .flags_o   (conv_flags)
   );

   assign conv_flag_bits = conv_flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= conv_res;
      end
   end

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flags_q[gi] <= 1'b0;
         else if (flag_clr)  flags_q[gi] <= in_valid & conv_flag_bits[gi];
         else if (in_valid)  flags_q[gi] <= flags_q[gi] | conv_flag_bits[gi];
      end
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/rto_checker.sv
module rto_checker #(
   parameter int IN_EXP_W  = 11,
   parameter int IN_FRAC_W = 52,
   parameter int OUT_EXP_W = 8,
   parameter int OUT_FRAC_W = 23
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic                                   in_valid,
   input logic [IN_EXP_W+IN_FRAC_W:0]            in_data,
   input logic                                   flag_clr,
   input logic                                   out_valid,
   input logic [OUT_EXP_W+OUT_FRAC_W:0]          out_data,
   input logic [3:0]                             flags_o
);

   localparam int DROP = IN_FRAC_W - OUT_FRAC_W;

   logic [IN_EXP_W-1:0]   in_exp;
   logic [OUT_EXP_W-1:0]  res_exp;
   logic [OUT_FRAC_W-1:0] res_frac;

   assign in_exp   = in_data[IN_EXP_W+IN_FRAC_W-1:IN_FRAC_W];
   assign res_exp  = out_data[OUT_EXP_W+OUT_FRAC_W-1:OUT_FRAC_W];
   assign res_frac = out_data[OUT_FRAC_W-1:0];

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_data_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   p_inexact_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_exp != '1 && in_data[DROP-1:0] != '0) |=> flags_o[0]);
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_exp != '1) |=> res_exp != '1);
   p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_exp == '1 && res_frac != '0) |-> res_frac[OUT_FRAC_W-1]);
   p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
   p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !in_valid) |=> flags_o == 4'b0000);

endmodule

bind f64_to_f32_odd rto_checker #(
   .IN_EXP_W(IN_EXP_W), .IN_FRAC_W(IN_FRAC_W),
   .OUT_EXP_W(OUT_EXP_W), .OUT_FRAC_W(OUT_FRAC_W)
) u_rto_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .flag_clr(flag_clr), .out_valid(out_valid), .out_data(out_data),
   .flags_o(flags_o)
);

// File: tb/f64_to_f32_odd_tb_top.sv
`timescale 1ns/1ps
module f64_to_f32_odd_tb_top;

   localparam real CLK_P = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [31:0] out_data;
   logic [3:0]  flags_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [3:0]  exp_flags = '0;
   logic [31:0] last_data = '0;

   always #(CLK_P/2) clk = ~clk;

   f64_to_f32_odd dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .flag_clr(flag_clr), .out_valid(out_valid), .out_data(out_data),
      .flags_o(flags_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // reference: {flags[3:0], result[31:0]} built from the requirement text
   function automatic logic [35:0] model(input logic [63:0] a);
      logic        s;
      int          e;
      int          be;
      int          sh;
      logic [51:0] f;
      logic [52:0] q;
      logic [31:0] r;
      logic [3:0]  fl;
      logic        st;
      s = a[63]; e = int'(a[62:52]); f = a[51:0]; fl = '0; r = '0;
      if (e == 2047) begin
         if (f == '0) r = {s, 8'hFF, 23'h0};
         else begin
            r = {s, 8'hFF, 1'b1, f[50:29]};
            fl[3] = ~f[51];
         end
      end else if (e == 0 && f == '0) begin
         r = {s, 31'h0};
      end else begin
         q = {(e != 0), f};
         if (e == 0) e = 1;
         be = e - 896;
         if (be > 254) begin
            r = {s, 31'h7F7FFFFF};
            fl = 4'b0101;
         end else if (be >= 1) begin
            st = |f[28:0];
            r = {s, be[7:0], f[51:30], f[29] | st};
            fl[0] = st;
         end else begin
            sh = 30 - be;
            st = 1'b0;
            for (int k = 0; k < sh && k < 60; k++) begin
               st = st | q[0];
               q = q >> 1;
            end
            r = {s, 8'h00, q[22:1], q[0] | st};
            fl[0] = st;
            fl[1] = st;
         end
      end
      return {fl, r};
   endfunction

   function automatic string req_of(input logic [63:0] a);
      int e;
      e = int'(a[62:52]);
      if (e == 2047) return (a[51:0] == '0) ? "R5" : "R6";
      if (e == 0 && a[51:0] == '0) return "R5";
      if (e >= 1151) return "R3";
      if (e <= 896) return "R4";
      return "R2";
   endfunction

   task automatic do_op(input logic [63:0] a, input logic clr);
      logic [35:0] m;
      string rq;
      m  = model(a);
      rq = req_of(a);
      @(negedge clk);
      in_valid = 1'b1; in_data = a; flag_clr = clr;
      if (clr) exp_flags = m[35:32];
      else     exp_flags = exp_flags | m[35:32];
      @(negedge clk);
      chk(out_valid == 1'b1, "R1", 64'(out_valid), 64'(1));
      chk(out_data == m[31:0], rq, 64'(out_data), 64'(m[31:0]));
      chk(flags_o == exp_flags, clr ? "R8" : "R7", 64'(flags_o), 64'(exp_flags));
      last_data = m[31:0];
      in_valid = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic do_idle(input logic clr);
      @(negedge clk);
      in_valid = 1'b0; flag_clr = clr;
      if (clr) exp_flags = '0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'(0));
      chk(out_data == last_data, "R1", 64'(out_data), 64'(last_data));
      chk(flags_o == exp_flags, clr ? "R8" : "R7", 64'(flags_o), 64'(exp_flags));
      flag_clr = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] a;
      int mode;
      int ex;
      repeat (3) @(negedge clk);
      // R9: outputs zero while reset is held
      chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'(0));
      chk(out_data == '0, "R9", 64'(out_data), 64'(0));
      chk(flags_o == '0, "R9", 64'(flags_o), 64'(0));
      rst_n = 1'b1;
      do_idle(1'b0);

      do_op(64'h3FF0_0000_0000_0000, 1'b0);   // R2 exact 1.0
      do_op(64'h3FF0_0000_2000_0000, 1'b0);   // R2 exact, bit 29 kept
      do_op(64'h3FF0_0000_0000_0001, 1'b0);   // R2 sticky into LSB
      do_op(64'hC7EF_FFFF_FFFF_FFFF, 1'b0);   // R2 top of range
      do_idle(1'b1);                          // R8 clear alone
      do_op(64'h47F0_0000_0000_0000, 1'b0);   // R3 just past range
      do_op(64'hFFEF_FFFF_FFFF_FFFF, 1'b1);   // R3 negative, with clear (R8)
      do_op(64'h3800_0000_0000_0000, 1'b1);   // R4 exact tiny
      do_op(64'h36A0_0000_0000_0000, 1'b0);   // R4 smallest subnormal exact
      do_op(64'h3690_0000_0000_0000, 1'b0);   // R4 all shifted away
      do_op(64'h8000_0000_0000_0001, 1'b0);   // R4 input subnormal
      do_idle(1'b1);
      do_op(64'h0000_0000_0000_0000, 1'b0);   // R5
      do_op(64'h8000_0000_0000_0000, 1'b0);   // R5
      do_op(64'h7FF0_0000_0000_0000, 1'b0);   // R5
      do_op(64'hFFF0_0000_0000_0000, 1'b0);   // R5, flags stay empty
      do_op(64'h7FF8_0000_0000_0000, 1'b0);   // R6 quiet
      do_op(64'hFFF4_0000_2000_0000, 1'b0);   // R6 signaling with payload
      do_op(64'h7FF0_0000_0000_0001, 1'b0);   // R6 signaling, empty payload
      do_idle(1'b0);                          // R7 flags retained

      void'($urandom(32'h5EED_0F2D));
      for (int i = 0; i < 3000; i++) begin
         mode = int'($urandom % 8);
         case (mode)
            0: ex = int'($urandom % 2048);
            6: ex = ($urandom % 2 == 0) ? 0 : 2047;
            7: begin
               case ($urandom % 5)
                  0: ex = 896;
                  1: ex = 897;
                  2: ex = 1150;
                  3: ex = 1151;
                  default: ex = 873;
               endcase
            end
            default: ex = 860 + int'($urandom % 300);
         endcase
         a = {$urandom, $urandom};
         a[62:52] = 11'(ex);
         if ($urandom % 4 == 0) a[28:0] = '0;
         if ($urandom % 25 == 0) do_idle($urandom % 2 == 0);
         do_op(a, ($urandom % 16) == 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule